// File: doc/BRIEF.md
# Wide-request to 64-bit Wishbone splitter

This block sits between a 128-bit load/store path and a 64-bit Wishbone classic bus. Each incoming request is a read or a write. It carries a line address, a 16-lane byte mask and, for writes, 128 bits of data. The block looks at the two 64-bit halves of the mask and runs a bus cycle only for a half that has at least one byte lane set. A request that touches only one half costs one bus cycle. A request that touches both halves costs two, and they run back to back.

For reads, the block places the data from each acknowledged cycle in its own 64-bit lane of a 128-bit response. When the sequence is over it raises a one-cycle completion pulse. A bus error stops the sequence, and the completion pulse then comes with an error flag. A request with an empty mask completes at once and starts no bus cycle.

Requests are offered with `req_valid` and taken on any clock edge where `busy` is low. The number of bus lanes is set by the ratio of the line width to the bus width. The parameters are generic, but the lane ordering rules below are written for the default two lanes.

Top module: `wbs_split128`

## Requirements
- R1: Lane i (lane 0 = bytes 0..7, lane 1 = bytes 8..15) is active when any bit of `req_mask[8i+7:8i]` is set. Exactly one bus cycle is issued per active lane, and none for an inactive lane.
- R2: Active lanes are issued in ascending order, so lane 0 goes first. The address of lane i is the request address with its low 4 bits forced to zero, plus 8·i.
- R3: During the cycle for lane i, `wb_sel` equals `req_mask[8i+7:8i]` and `wb_we` equals `req_we`. `wb_dat_o` equals `req_wdata[64i+63:64i]` for writes and is zero for reads.
- R4: Once started, a bus cycle keeps `wb_cyc` and `wb_stb` high, and keeps address, select, write enable and write data stable, until `wb_ack` or `wb_err` is sampled.
- R5: `wb_stb` is high exactly when `wb_cyc` is high. A second cycle begins only after the first has been terminated, so its strobe is never seen by the slave before the first acknowledge.
- R6: After a read completes, `rsp_rdata[64i+63:64i]` holds the data acknowledged for lane i. Lanes that were not read hold zero. The response holds until the next request is accepted.
- R7: `rsp_done` is high for exactly one cycle, in the cycle after the clock edge that sampled the terminating acknowledge or error of the last cycle.
- R8: A request with an all-zero mask gives `rsp_done` in the cycle after acceptance, with `rsp_err` low and no bus cycle.
- R9: `wb_err` ends the sequence: no further lane is issued, and `rsp_err` is high together with that `rsp_done` and at no other time.
- R10: A `req_valid` offered while `busy` is high is ignored: it causes no bus cycle and does not change the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered; taken when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the line (low bits ignored) |
| req_mask | input | LINE_W/8 | Byte enables of the wide request |
| req_wdata | input | LINE_W | Write data of the wide request |
| busy | output | 1 | A sequence is in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Bus error, valid with rsp_done |
| rsp_rdata | output | LINE_W | Assembled read data |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | ADDR_W | Wishbone byte address |
| wb_sel | output | BUS_W/8 | Wishbone byte selects |
| wb_dat_o | output | BUS_W | Wishbone write data |
| wb_dat_i | input | BUS_W | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_err | input | 1 | Wishbone error |

## Verification
The bench builds the block with its defaults: a 128-bit line, a 64-bit bus and a 32-bit address. This gives two lanes, so every lane pattern can be reached: lower only, upper only, both, and neither. Random request addresses with non-zero low bits exercise the alignment rule. The slave model in the bench adds zero to three wait states, which tests hold-until-acknowledge behaviour and the timing of back-to-back cycles. It also injects errors on either the first or the second lane, and a request is offered while the block is busy.

// File: rtl/wbs_split_pkg.sv
package wbs_split_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/wbs_lane_decode.sv
module wbs_lane_decode #(
  parameter int LANES = 2,
  parameter int SEL_W = 8
) (
  input  logic [LANES*SEL_W-1:0] mask,
  output logic [LANES-1:0]       active
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign active[g] = |mask[g*SEL_W +: SEL_W];
  end
endmodule

// File: rtl/wbs_lane_pick.sv
module wbs_lane_pick #(
  parameter int LANES  = 2,
  parameter int LIDX_W = 1
) (
  input  logic [LANES-1:0]  vec,
  output logic [LIDX_W-1:0] idx,
  output logic [LANES-1:0]  onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx    = LIDX_W'(i);
        onehot = LANES'(1) << i;
      end
    end
  end
endmodule

// File: rtl/wbs_seq.sv
module wbs_seq
  import wbs_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int BUS_W  = 64,
  parameter int LANES  = LINE_W / BUS_W,
  parameter int LIDX_W = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_we,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LINE_W/8-1:0]   req_mask,
  input  logic [LINE_W-1:0]     req_wdata,
  input  logic [LANES-1:0]      active,
  input  logic [LIDX_W-1:0]     pick_idx,
  input  logic [LANES-1:0]      pick_oh,
  output logic [LANES-1:0]      pend,
  output logic                  busy,
  output logic [LIDX_W-1:0]     cur_lane,
  output logic                  wb_cyc,
  output logic                  wb_stb,
  output logic                  wb_we,
  output logic [ADDR_W-1:0]     wb_adr,
  output logic [BUS_W/8-1:0]    wb_sel,
  output logic [BUS_W-1:0]      wb_dat_o,
  input  logic                  wb_ack,
  input  logic                  wb_err,
  output logic                  done,
  output logic                  err
);
  localparam int SEL_W      = BUS_W / 8;
  localparam int LINE_BYTES = LINE_W / 8;
  localparam int BUS_OFS    = $clog2(SEL_W);

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(LINE_BYTES - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] lane_off(input logic [LIDX_W-1:0] i);
    return ADDR_W'(i) << BUS_OFS;
  endfunction

  function automatic logic [SEL_W-1:0] lane_sel(input logic [LINE_BYTES-1:0] m,
                                                input logic [LIDX_W-1:0] i);
    return m[i*SEL_W +: SEL_W];
  endfunction

  function automatic logic [BUS_W-1:0] lane_data(input logic [LINE_W-1:0] d,
                                                 input logic [LIDX_W-1:0] i);
    return d[i*BUS_W +: BUS_W];
  endfunction

  seq_state_t             state_q;
  logic [LANES-1:0]       pend_q;
  logic [LIDX_W-1:0]      lane_q;
  logic                   we_q;
  logic [LINE_W-1:0]      wdata_q;
  logic [LINE_BYTES-1:0]  mask_q;
  logic [ADDR_W-1:0]      base_q;
  logic                   cyc_q;
  logic [ADDR_W-1:0]      adr_q;
  logic [SEL_W-1:0]       sel_q;
  logic [BUS_W-1:0]       dat_q;
  logic                   done_q;
  logic                   err_q;
  logic                   term;

  assign term = wb_ack | wb_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      lane_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      cyc_q   <= 1'b0;
      adr_q   <= '0;
      sel_q   <= '0;
      dat_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            we_q    <= req_we;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
            base_q  <= line_base(req_addr);
            if (active == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_BUS;
              pend_q  <= active & ~pick_oh;
              lane_q  <= pick_idx;
              cyc_q   <= 1'b1;
              adr_q   <= line_base(req_addr) + lane_off(pick_idx);
              sel_q   <= lane_sel(req_mask, pick_idx);
              dat_q   <= req_we ? lane_data(req_wdata, pick_idx) : '0;
            end
          end
        end
        ST_BUS: begin
          if (term) begin
            if (wb_err || pend_q == '0) begin
              state_q <= ST_IDLE;
              pend_q  <= '0;
              cyc_q   <= 1'b0;
              done_q  <= 1'b1;
              err_q   <= wb_err;
            end else begin
              pend_q <= pend_q & ~pick_oh;
              lane_q <= pick_idx;
              adr_q  <= base_q + lane_off(pick_idx);
              sel_q  <= lane_sel(mask_q, pick_idx);
              dat_q  <= we_q ? lane_data(wdata_q, pick_idx) : '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pend     = pend_q;
  assign busy     = (state_q == ST_BUS);
  assign cur_lane = lane_q;
  assign wb_cyc   = cyc_q;
  assign wb_stb   = cyc_q;
  assign wb_we    = we_q & cyc_q;
  assign wb_adr   = adr_q;
  assign wb_sel   = sel_q;
  assign wb_dat_o = dat_q;
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/wbs_gather.sv
module wbs_gather #(
  parameter int BUS_W  = 64,
  parameter int LANES  = 2,
  parameter int LIDX_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   capture,
  input  logic [LIDX_W-1:0]      lane,
  input  logic [BUS_W-1:0]       din,
  output logic [LANES*BUS_W-1:0] line
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUS_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (clear) begin
        word_q <= '0;
      end else if (capture && lane == LIDX_W'(g)) begin
        word_q <= din;
      end
    end
    assign line[g*BUS_W +: BUS_W] = word_q;
  end
endmodule

// File: rtl/wbs_split128.sv
module wbs_split128 #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int BUS_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LINE_W/8-1:0]  req_mask,
  input  logic [LINE_W-1:0]    req_wdata,
  output logic                 busy,
  output logic                 rsp_done,
  output logic                 rsp_err,
  output logic [LINE_W-1:0]    rsp_rdata,
  output logic                 wb_cyc,
  output logic                 wb_stb,
  output logic                 wb_we,
  output logic [ADDR_W-1:0]    wb_adr,
  output logic [BUS_W/8-1:0]   wb_sel,
  output logic [BUS_W-1:0]     wb_dat_o,
  input  logic [BUS_W-1:0]     wb_dat_i,
  input  logic                 wb_ack,
  input  logic                 wb_err
);
  localparam int LANES  = LINE_W / BUS_W;
  localparam int SEL_W  = BUS_W / 8;
  localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0]  active;
  logic [LANES-1:0]  pend;
  logic [LANES-1:0]  pick_src;
  logic [LIDX_W-1:0] pick_idx;
  logic [LANES-1:0]  pick_oh;
  logic [LIDX_W-1:0] cur_lane;

  // named events for the checker
  logic accept_evt;
  logic zero_req_evt;
  logic capture_evt;
  logic last_term_evt;

  assign accept_evt    = req_valid & ~busy;
  assign zero_req_evt  = accept_evt & (active == '0);
  assign capture_evt   = wb_cyc & wb_ack & ~wb_err;
  assign last_term_evt = wb_cyc & (wb_ack | wb_err) & (wb_err | (pend == '0));
  assign pick_src      = busy ? pend : active;

  wbs_lane_decode #(.LANES(LANES), .SEL_W(SEL_W)) decode_i (
    .mask   (req_mask),
    .active (active)
  );

  wbs_lane_pick #(.LANES(LANES), .LIDX_W(LIDX_W)) pick_i (
    .vec    (pick_src),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  wbs_seq #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .BUS_W  (BUS_W),
    .LANES  (LANES),
    .LIDX_W (LIDX_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_mask  (req_mask),
    .req_wdata (req_wdata),
    .active    (active),
    .pick_idx  (pick_idx),
    .pick_oh   (pick_oh),
    .pend      (pend),
    .busy      (busy),
    .cur_lane  (cur_lane),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_adr    (wb_adr),
    .wb_sel    (wb_sel),
    .wb_dat_o  (wb_dat_o),
    .wb_ack    (wb_ack),
    .wb_err    (wb_err),
    .done      (rsp_done),
    .err       (rsp_err)
  );

  wbs_gather #(.BUS_W(BUS_W), .LANES(LANES), .LIDX_W(LIDX_W)) gather_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept_evt),
    .capture (capture_evt),
    .lane    (cur_lane),
    .din     (wb_dat_i),
    .line    (rsp_rdata)
  );
endmodule

// File: rtl/wbs_split128_chk.sv
module wbs_split128_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_we,
  input logic [ADDR_W-1:0] wb_adr,
  input logic [BUS_W/8-1:0] wb_sel,
  input logic [BUS_W-1:0]  wb_dat_o,
  input logic              wb_ack,
  input logic              wb_err,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              busy,
  input logic              zero_req_evt,
  input logic              last_term_evt
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_stb && !wb_ack && !wb_err) |=>
      (wb_cyc && wb_stb && $stable(wb_adr) && $stable(wb_sel) &&
       $stable(wb_we) && $stable(wb_dat_o)));

  p_stb_cyc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb == wb_cyc);

  p_sel_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> (wb_sel != '0));

  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_term_evt |=> (rsp_done && !wb_cyc));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_zero_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req_evt |=> (rsp_done && !rsp_err && !wb_cyc));

  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_err) |=> (!wb_cyc && rsp_err));

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  p_cyc_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc |-> busy);
endmodule

bind wbs_split128 wbs_split128_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wb_cyc        (wb_cyc),
  .wb_stb        (wb_stb),
  .wb_we         (wb_we),
  .wb_adr        (wb_adr),
  .wb_sel        (wb_sel),
  .wb_dat_o      (wb_dat_o),
  .wb_ack        (wb_ack),
  .wb_err        (wb_err),
  .rsp_done      (rsp_done),
  .rsp_err       (rsp_err),
  .busy          (busy),
  .zero_req_evt  (zero_req_evt),
  .last_term_evt (last_term_evt)
);

// File: tb/wbs_split128_tb_top.sv
`timescale 1ns/1ps
module wbs_split128_tb_top;
  localparam int AW = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]  req_mask = '0;
  logic [127:0] req_wdata = '0;
  logic         busy, rsp_done, rsp_err;
  logic [127:0] rsp_rdata;
  logic         wb_cyc, wb_stb, wb_we;
  logic [AW-1:0] wb_adr;
  logic [7:0]   wb_sel;
  logic [63:0]  wb_dat_o;
  logic [63:0]  wb_dat_i = '0;
  logic         wb_ack = 1'b0;
  logic         wb_err = 1'b0;

  int checks = 0;
  int errors = 0;
  int unsigned cyc_cnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  wbs_split128 dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_sel(wb_sel), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack(wb_ack), .wb_err(wb_err)
  );

  // slave model log
  int           n_txn;
  int           err_at;
  logic [AW-1:0] log_adr [4];
  logic [7:0]   log_sel [4];
  logic         log_we  [4];
  logic [63:0]  log_dat [4];
  int unsigned  term_cnt;
  int unsigned  slv_dly;

  function automatic logic [63:0] rd_pat(input logic [AW-1:0] a);
    return {a ^ 32'hA5C3_0F11, ~a};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    int wcnt;
    n_txn = 0; err_at = -1; term_cnt = 0; wcnt = 0; slv_dly = 0;
    forever begin
      @(negedge clk);
      if (wb_ack || wb_err) begin
        wb_ack = 1'b0;
        wb_err = 1'b0;
      end else if (rst_n && wb_cyc && wb_stb) begin
        if (wcnt < int'(slv_dly)) begin
          wcnt++;
        end else begin
          if (n_txn < 4) begin
            log_adr[n_txn] = wb_adr;
            log_sel[n_txn] = wb_sel;
            log_we[n_txn]  = wb_we;
            log_dat[n_txn] = wb_dat_o;
          end
          wb_dat_i = rd_pat(wb_adr);
          if (n_txn == err_at) wb_err = 1'b1;
          else                 wb_ack = 1'b1;
          n_txn++;
          term_cnt = cyc_cnt;
          wcnt = 0;
          slv_dly = $urandom % 4;
        end
      end
    end
  end

  task automatic do_req(input bit we, input logic [AW-1:0] addr,
                        input logic [15:0] mask, input logic [127:0] wdata,
                        input int inj_err, input bit poke);
    int exp_n;
    int lanes [2];
    logic [127:0] exp_rd;
    bit exp_err;
    int waited;
    int unsigned done_cnt;
    logic [AW-1:0] base;
    @(negedge clk);
    while (busy) @(negedge clk);
    n_txn = 0;
    err_at = inj_err;
    req_valid = 1'b1; req_we = we; req_addr = addr;
    req_mask = mask; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_done && waited < 60) begin
      if (poke && waited == 0 && busy) begin
        req_valid = 1'b1; req_we = ~we; req_addr = addr ^ 32'h100;
        req_mask = 16'hFFFF; req_wdata = ~wdata;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    req_valid = 1'b0;
    done_cnt = cyc_cnt;
    // expected values from the requirements
    base = addr & ~32'hF;
    exp_n = 0;
    exp_rd = '0;
    exp_err = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (mask[8*i +: 8] != 8'h00 && !exp_err) begin
        lanes[exp_n] = i;
        if (exp_n == inj_err) exp_err = 1'b1;
        else if (!we) exp_rd[64*i +: 64] = rd_pat(base + AW'(8*i));
        exp_n++;
      end
    end
    check(rsp_done == 1'b1, "R7 done seen", 128'(rsp_done), 128'd1);
    check(n_txn == exp_n, "R1 R9 R10 bus cycle count", 128'(n_txn), 128'(exp_n));
    for (int k = 0; k < exp_n && k < n_txn; k++) begin
      check(log_adr[k] == base + AW'(8*lanes[k]), "R2 lane address",
            128'(log_adr[k]), 128'(base + AW'(8*lanes[k])));
      check(log_sel[k] == mask[8*lanes[k] +: 8], "R3 select",
            128'(log_sel[k]), 128'(mask[8*lanes[k] +: 8]));
      check(log_we[k] == we, "R3 write enable", 128'(log_we[k]), 128'(we));
      check(log_dat[k] == (we ? wdata[64*lanes[k] +: 64] : 64'd0), "R3 write data",
            128'(log_dat[k]), 128'(we ? wdata[64*lanes[k] +: 64] : 64'd0));
    end
    check(rsp_err == exp_err, "R9 error flag", 128'(rsp_err), 128'(exp_err));
    if (!we)
      check(rsp_rdata == exp_rd, "R6 read data", rsp_rdata, exp_rd);
    if (exp_n == 0)
      check(waited == 0, "R8 zero mask latency", 128'(waited), 128'd0);
    else
      check(done_cnt == term_cnt + 1, "R7 done latency",
            128'(done_cnt), 128'(term_cnt + 1));
    @(negedge clk);
    check(rsp_done == 1'b0, "R7 single pulse", 128'(rsp_done), 128'd0);
    check(rsp_err == 1'b0, "R9 error only with done", 128'(rsp_err), 128'd0);
    check(n_txn == exp_n, "R10 no extra cycle", 128'(n_txn), 128'(exp_n));
    if (!we)
      check(rsp_rdata == exp_rd, "R6 response held", rsp_rdata, exp_rd);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && rsp_done == 1'b0 && wb_cyc == 1'b0 && wb_stb == 1'b0,
          "R5 reset state", {busy, rsp_done, wb_cyc, wb_stb}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wb_cyc == 1'b0 && rsp_done == 1'b0, "R8 idle after reset",
          {wb_cyc, rsp_done}, 128'd0);
    // directed corner cases
    do_req(1'b0, 32'h1000_0007, 16'h00FF, '0, -1, 1'b0);            // R1 lower only
    do_req(1'b0, 32'h1000_0013, 16'h8000, '0, -1, 1'b0);            // R1 upper only
    do_req(1'b1, 32'h2000_000C, 16'h0180, {64'hDEAD_BEEF_0123_4567,
           64'h89AB_CDEF_F00D_CAFE}, -1, 1'b0);                     // R2 both halves
    do_req(1'b0, 32'h3000_0000, 16'hFFFF, '0, -1, 1'b0);            // R6 full read
    do_req(1'b0, 32'h3000_0040, 16'h0000, '0, -1, 1'b0);            // R8 empty mask
    do_req(1'b1, 32'h3000_0050, 16'h0000, {2{64'h1111_2222_3333_4444}}, -1, 1'b0);
    do_req(1'b0, 32'h4000_0020, 16'h0F0F, '0, 0, 1'b0);             // R9 err first
    do_req(1'b0, 32'h4000_0030, 16'hF0F0, '0, 1, 1'b0);             // R9 err second
    do_req(1'b1, 32'h5000_0000, 16'hFFFF, {4{32'h5A5A_A5A5}}, -1, 1'b1); // R10 poke
    do_req(1'b0, 32'h5000_0100, 16'h0003, '0, -1, 1'b1);            // R10 poke read
    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [15:0] m;
      int sel;
      int e;
      sel = $urandom % 10;
      m = 16'($urandom);
      if (sel < 3)      m[15:8] = 8'h00;
      else if (sel < 6) m[7:0]  = 8'h00;
      else if (sel == 9) m = 16'h0000;
      if (m[7:0] == 8'h00 && sel >= 6 && sel < 9) m[0] = 1'b1;
      if (m[15:8] == 8'h00 && sel >= 6 && sel < 9) m[15] = 1'b1;
      e = (($urandom % 8) == 0) ? int'($urandom % 2) : -1;
      do_req(1'($urandom), $urandom, m,
             {$urandom, $urandom, $urandom, $urandom}, e, (($urandom % 5) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule